// File: doc/BRIEF.md
# Cascaded serial-in latched-output register

This block turns a serial bit stream into two parallel bytes. Two 8-bit shift stages sit back to back, so the most significant bit of the low stage feeds bit 0 of the high stage and the pair behaves as one 16-bit chain. Each rising edge of the shift clock moves every bit one place toward the far end and takes in a new bit at bit 0 of the low stage. The bit that leaves the far end appears on a serial spill output, which can feed a further device.

The parallel outputs do not follow the chain while it shifts. A rising edge on the store clock copies the whole chain into a bank of storage registers in one step. While the active-low output enable is low, the two parallel ports show those stored bytes. While it is high, they float at high impedance. An active-low asynchronous clear empties the chain and the spill bit and leaves the stored bytes alone.

A controller can therefore drive a wide parallel load, such as the segment and digit lines of a multiplexed display, from three lines: data, shift clock and store clock.

Top module: `cascade_sipo_latch`

## Requirements
- R1: While `clr_n` is low, the shift chain and `spill` are forced to 0 without waiting for a clock edge. The stored bytes keep their values, and a store edge after the clear makes both parallel ports read 0.
- R2: On each rising edge of `shift_clk`, the value of `ser_in` enters bit 0 of the low stage, which is `par_lo[0]` after a store.
- R3: Bit 7 of the low stage feeds bit 0 of the high stage. After 9 shift edges following a clear, the first bit sent sits at `par_hi[0]` after a store, and `par_lo` reads 0.
- R4: After a clear and exactly 14 shift edges, the first bit sent sits at bit 5 of the high stage, that is `par_hi[5]` after a store.
- R5: One rising edge of `store_clk` copies all 16 chain bits into the stored bytes together: the low stage to `par_lo` and the high stage to `par_hi`.
- R6: Shift edges with no store edge leave `par_lo` and `par_hi` unchanged.
- R7: While `oe_n` is high, `par_lo` and `par_hi` are high-impedance on every bit. While `oe_n` is low, they show the stored bytes.
- R8: After each shift edge, `spill` holds the bit that was in bit 7 of the high stage just before that edge.
- R9: Every shift edge moves each chain bit one place toward the spill end. After 16 edges, the first bit sent is at `par_hi[7]` and the last is at `par_lo[0]` once stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data, taken on each rising shift edge |
| shift_clk | input | 1 | Shift clock; each rising edge advances the chain |
| store_clk | input | 1 | Store clock; a rising edge copies the chain to the stored bytes |
| oe_n | input | 1 | Active-low output enable for both parallel ports |
| clr_n | input | 1 | Active-low asynchronous clear of the chain and spill bit |
| par_lo | output | STAGE_W | Stored low stage, high-impedance while `oe_n` is high |
| par_hi | output | STAGE_W | Stored high stage, high-impedance while `oe_n` is high |
| spill | output | 1 | Bit pushed out of the far end of the chain on the last shift edge |

## Verification
The properties are sampled on the rising shift edge. They assume that `ser_in` is steady around that edge and that `clr_n` returns high well before the next shift edge. They also assume that store edges never coincide with shift edges, so each stored value is a settled chain. The stimulus therefore changes `ser_in` one bench cycle before it raises `shift_clk`, gives every clear, shift pulse and store pulse its own bench cycles, and compares the ports only after the edge it is checking has settled.

// File: rtl/cascade_sipo_latch.sv
module cascade_sipo_latch #(
  parameter int STAGE_W = 8
) (
  input  logic               ser_in,
  input  logic               shift_clk,
  input  logic               store_clk,
  input  logic               oe_n,
  input  logic               clr_n,
  output logic [STAGE_W-1:0] par_lo,
  output logic [STAGE_W-1:0] par_hi,
  output logic               spill
);
  localparam int STAGES  = 2;
  localparam int CHAIN_W = STAGES * STAGE_W;

  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] held;
  logic               spill_q;
  logic               sh_armed;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic               feed;
    logic [STAGE_W-1:0] sr;
    logic [STAGE_W-1:0] hd;

    if (g == 0) begin : g_head
      assign feed = ser_in;
    end else begin : g_link
      assign feed = chain[g*STAGE_W-1];
    end

    always_ff @(posedge shift_clk or negedge clr_n) begin
      if (!clr_n) sr <= '0;
      else        sr <= {sr[STAGE_W-2:0], feed};
    end

    always_ff @(posedge store_clk) hd <= sr;

    assign chain[g*STAGE_W +: STAGE_W] = sr;
    assign held[g*STAGE_W +: STAGE_W]  = hd;
  end

  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) spill_q <= 1'b0;
    else        spill_q <= chain[CHAIN_W-1];
  end

  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) sh_armed <= 1'b0;
    else        sh_armed <= 1'b1;
  end

  assign spill  = spill_q;
  assign par_lo = oe_n ? {STAGE_W{1'bz}} : held[STAGE_W-1:0];
  assign par_hi = oe_n ? {STAGE_W{1'bz}} : held[CHAIN_W-1:STAGE_W];

  p_entry_r2: assert property (@(posedge shift_clk) disable iff (!clr_n || !sh_armed)
    chain[0] == $past(ser_in))
    else $error("p_entry_r2");

  p_link_r3: assert property (@(posedge shift_clk) disable iff (!clr_n || !sh_armed)
    chain[STAGE_W] == $past(chain[STAGE_W-1]))
    else $error("p_link_r3");

  p_move_r9: assert property (@(posedge shift_clk) disable iff (!clr_n || !sh_armed)
    chain[CHAIN_W-1:1] == $past(chain[CHAIN_W-2:0]))
    else $error("p_move_r9");

  p_spill_r8: assert property (@(posedge shift_clk) disable iff (!clr_n || !sh_armed)
    spill == $past(chain[CHAIN_W-1]))
    else $error("p_spill_r8");
endmodule

// File: tb/cascade_sipo_latch_tb_top.sv
`timescale 1ns/1ps
module cascade_sipo_latch_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       ser_in = 1'b0, shift_clk = 1'b0, store_clk = 1'b0;
  logic       oe_n = 1'b0, clr_n = 1'b0;
  logic [7:0] par_lo, par_hi;
  logic       spill;

  cascade_sipo_latch #(.STAGE_W(8)) dut_i (
    .ser_in(ser_in), .shift_clk(shift_clk), .store_clk(store_clk),
    .oe_n(oe_n), .clr_n(clr_n), .par_lo(par_lo), .par_hi(par_hi), .spill(spill)
  );

  typedef struct {
    string      tag;
    logic [7:0] lo;
    logic [7:0] hi;
    logic       sp;
    bit         use_sp;
  } exp_t;

  exp_t        sb_q[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;
  logic [15:0] m_chain = '0;
  logic [15:0] m_held  = '0;
  logic        m_sp    = 1'b0;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_tests++;
      if (par_lo !== e.lo || par_hi !== e.hi || (e.use_sp && spill !== e.sp)) begin
        n_fail++;
        $display("FAIL %s: got hi=%b lo=%b spill=%b, expected hi=%b lo=%b spill=%b",
                 e.tag, par_hi, par_lo, spill, e.hi, e.lo, e.sp);
      end
    end
  end

  task automatic shift_bit(input logic b);
    @(posedge clk) ser_in = b;
    @(posedge clk) shift_clk = 1'b1;
    m_sp = m_chain[15];
    m_chain = {m_chain[14:0], b};
    @(posedge clk) shift_clk = 1'b0;
  endtask

  task automatic shift_word(input logic [15:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic store_now();
    @(posedge clk) store_clk = 1'b1;
    m_held = m_chain;
    @(posedge clk) store_clk = 1'b0;
  endtask

  task automatic clear_now();
    @(posedge clk) clr_n = 1'b0;
    m_chain = '0;
    m_sp = 1'b0;
    @(posedge clk);
    @(posedge clk) clr_n = 1'b1;
  endtask

  task automatic expect_out(input string tag, input bit use_sp);
    exp_t e;
    @(posedge clk);
    e.tag = tag;
    e.lo = oe_n ? 8'hzz : m_held[7:0];
    e.hi = oe_n ? 8'hzz : m_held[15:8];
    e.sp = m_sp;
    e.use_sp = use_sp;
    sb_q.push_back(e);
    @(negedge clk);
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    clear_now();
    store_now();
    expect_out("R1 reset state zero", 1);

    shift_word(16'hA5C3, 16);
    expect_out("R6 no store keeps outputs", 0);
    store_now();
    expect_out("R5 R9 full word stored", 0);

    @(posedge clk) oe_n = 1'b1;
    expect_out("R7 outputs float", 0);
    @(posedge clk) oe_n = 1'b0;
    expect_out("R7 outputs return", 0);

    shift_bit(1'b0);
    expect_out("R8 spill first bit", 1);
    shift_bit(1'b1);
    expect_out("R8 spill second bit", 1);

    clear_now();
    expect_out("R1 clear keeps stored bytes", 1);
    store_now();
    expect_out("R1 store after clear is zero", 1);

    shift_bit(1'b1);
    store_now();
    expect_out("R2 entry at bit 0", 0);

    clear_now();
    shift_word(16'h0100, 9);
    store_now();
    expect_out("R3 link into high stage", 0);

    clear_now();
    shift_word(16'h2000, 14);
    store_now();
    expect_out("R4 fourteen edges bit 5", 0);

    for (int k = 0; k < 8; k++) begin
      logic [15:0] w;
      w = 16'($urandom);
      for (int i = 15; i >= 0; i--) begin
        shift_bit(w[i]);
        expect_out("R8 R6 spill per edge", 1);
      end
      store_now();
      expect_out("R9 R5 random word", 1);
    end

    repeat (4) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule